// File: doc/BRIEF.md
# SPI flash hardware sequencer

This block lets software run complete serial-flash operations through a small 32-bit register window, without ever toggling the serial pins itself. Software first places a 24-bit flash address in one register. For a program cycle it also fills a 64-byte data buffer. It then writes a single control word that holds the cycle type, the byte count minus one and a start bit. The sequencer then does the rest on its own. It emits any required write-enable transaction and the command opcode. It sends the address most significant byte first. It then moves data between the buffer and the flash, and finally raises a completion or an error flag.

Software clears those flags by writing ones to them. Requests that the block cannot honour end with the error flag and no chip select activity. Two such cases exist: an unknown cycle type, and a read or program that would cross a 256-byte flash page. The serial port works in SPI mode 0 on one data lane. Its clock runs at the system clock divided by twice the `SCK_HALF_DIV` parameter.

Top module: `flash_seq_top`

## Requirements
- R1: After reset the control word (offset 0x04) and address register (offset 0x08) read 0, chip select is high and the serial clock is low.
- R2: Cycle type 0 (read) sends opcode 0x03, then the 24-bit address MSB first. It then clocks in N bytes into the buffer from byte 0 and sets the done flag (bit 0). Buffer byte 4k+j appears in bits 8j+7:8j of the register at offset 0x10+4k.
- R3: Cycle type 2 (program) first runs a separate one-byte 0x06 transaction. It then sends 0x02, the address, and N bytes taken from buffer byte 0 upward.
- R4: Cycle types 3 and 4 (4 KiB and 64 KiB erase) first run a separate 0x06 transaction. They then send 0x20 or 0xD8 with the address and nothing else, whatever the byte-count field holds.
- R5: Cycle type 8 (status read) sends 0x05 with no address and puts the one returned byte into buffer byte 0.
- R6: A read or program whose low address byte plus N exceeds 256 sets the error flag (bit 1) and runs no transaction. A request that ends exactly at the page end runs normally.
- R7: A cycle type outside {0,2,3,4,8} sets the error flag and never drives chip select low.
- R8: Writing a control word with a 1 in bit 0 or bit 1 clears that flag. A 0 leaves it unchanged.
- R9: Bit 5 of the control word reads 1 while a cycle runs. A start written during a cycle starts nothing and leaves the stored cycle type unchanged.
- R10: The serial clock is low whenever chip select is high (mode 0 idle level).
- R11: The byte count sits in control bits 29:24 as N-1, with the cycle type in bits 20:17 and the start bit at bit 16. The value 63 moves a full 64 bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the accessed register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The checks assume a single mode-0 flash on the bus. That flash changes MISO only after a falling clock edge, so MISO is settled at every rising edge. The checks also assume software does not write the address, buffer or cycle fields while a cycle runs. The block drops such writes, and the property that the stored cycle type stays frozen relies on it. The bench's flash model drives MISO on falling edges only. The stimulus polls the flags before each new request, except for one deliberate start issued mid-cycle to exercise R9.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int REG_AW     = 8;
  localparam int CNT_W      = 6;
  localparam int BUF_BYTES  = 1 << CNT_W;
  localparam int BUF_AW     = CNT_W;
  localparam int IDX_W      = CNT_W + 1;
  localparam int FADDR_W    = 24;
  localparam int PAGE_BITS  = 8;

  localparam logic [REG_AW-1:0] OFS_CTL  = 8'h04;
  localparam logic [REG_AW-1:0] OFS_ADDR = 8'h08;
  localparam logic [REG_AW-1:0] OFS_DATA = 8'h10;

  localparam int B_DONE   = 0;
  localparam int B_ERR    = 1;
  localparam int B_BUSY   = 5;
  localparam int B_GO     = 16;
  localparam int B_CYC_LO = 17;
  localparam int B_CNT_LO = 24;

  localparam logic [3:0] CYC_READ  = 4'd0;
  localparam logic [3:0] CYC_PROG  = 4'd2;
  localparam logic [3:0] CYC_ER4K  = 4'd3;
  localparam logic [3:0] CYC_ER64K = 4'd4;
  localparam logic [3:0] CYC_RDSR  = 4'd8;

  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_PROG  = 8'h02;
  localparam logic [7:0] OPC_ER4K  = 8'h20;
  localparam logic [7:0] OPC_ER64K = 8'hD8;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_WREN  = 8'h06;

  typedef enum logic [2:0] {
    S_IDLE, S_WREN, S_GAP, S_XFER, S_FIN
  } seq_state_e;
endpackage

// File: rtl/flash_seq_regs.sv
module flash_seq_regs
  import flash_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [REG_AW-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                fsm_busy,
  input  logic                set_done,
  input  logic                set_err,
  output logic                go_pulse,
  output logic [3:0]          cfg_cycle,
  output logic [CNT_W-1:0]    cfg_count,
  output logic [FADDR_W-1:0]  cfg_addr,
  input  logic [BUF_AW-1:0]   buf_idx,
  output logic [7:0]          buf_rbyte,
  input  logic                buf_we,
  input  logic [7:0]          buf_wbyte,
  output logic                flag_done,
  output logic                flag_err
);
  localparam int DW_AW = BUF_AW - 2;
  localparam logic [REG_AW-1:0] DATA_END = OFS_DATA + REG_AW'(BUF_BYTES);

  logic busy_any;
  logic ctl_wr, addr_wr, data_wr, in_data;
  logic cfg_en;
  logic [REG_AW-1:0] data_off;
  logic [DW_AW-1:0]  dw_idx;
  logic done_d, err_d, go_d;
  logic [7:0] mem_q [BUF_BYTES];

  assign busy_any = fsm_busy | go_pulse;
  assign in_data  = (bus_addr >= OFS_DATA) && (bus_addr < DATA_END);
  assign data_off = bus_addr - OFS_DATA;
  assign dw_idx   = data_off[BUF_AW-1:2];
  assign ctl_wr   = bus_wr && (bus_addr == OFS_CTL);
  assign addr_wr  = bus_wr && (bus_addr == OFS_ADDR) && !busy_any;
  assign data_wr  = bus_wr && in_data && !busy_any;
  assign cfg_en   = ctl_wr && !busy_any;

  // flag next state: hardware set wins over a same-cycle software clear
  always_comb begin
    done_d = set_done | (flag_done & ~(ctl_wr & bus_wdata[B_DONE]));
    err_d  = set_err  | (flag_err  & ~(ctl_wr & bus_wdata[B_ERR]));
    go_d   = cfg_en & bus_wdata[B_GO];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_done <= 1'b0;
      flag_err  <= 1'b0;
      go_pulse  <= 1'b0;
    end else begin
      flag_done <= done_d;
      flag_err  <= err_d;
      go_pulse  <= go_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_cycle <= '0;
      cfg_count <= '0;
    end else if (cfg_en) begin
      cfg_cycle <= bus_wdata[B_CYC_LO +: 4];
      cfg_count <= bus_wdata[B_CNT_LO +: CNT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_addr <= '0;
    else if (addr_wr) cfg_addr <= bus_wdata[FADDR_W-1:0];
  end

  // data buffer: sequencer port while busy, software port while idle
  always_ff @(posedge clk) begin
    if (buf_we) begin
      mem_q[buf_idx] <= buf_wbyte;
    end else if (data_wr) begin
      for (int j = 0; j < 4; j++) mem_q[{dw_idx, 2'(j)}] <= bus_wdata[8*j +: 8];
    end
  end

  assign buf_rbyte = mem_q[buf_idx];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_CTL) begin
      bus_rdata[B_DONE]               = flag_done;
      bus_rdata[B_ERR]                = flag_err;
      bus_rdata[B_BUSY]               = busy_any;
      bus_rdata[B_CYC_LO +: 4]        = cfg_cycle;
      bus_rdata[B_CNT_LO +: CNT_W]    = cfg_count;
    end else if (bus_addr == OFS_ADDR) begin
      bus_rdata[FADDR_W-1:0] = cfg_addr;
    end else if (in_data) begin
      for (int j = 0; j < 4; j++) bus_rdata[8*j +: 8] = mem_q[{dw_idx, 2'(j)}];
    end
  end
endmodule

// File: rtl/flash_seq_shifter.sv
module flash_seq_shifter #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       sck,
  output logic       mosi,
  input  logic       miso
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic             act_q, act_d;
  logic             sck_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       tx_q, tx_d, rx_d;
  logic             done_d;
  logic             tick;

  assign tick = (div_q == DIV_LAST);

  always_comb begin
    act_d  = act_q;
    sck_d  = sck;
    div_d  = div_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_byte;
    done_d = 1'b0;
    if (start) begin
      act_d = 1'b1;
      sck_d = 1'b0;
      div_d = '0;
      bit_d = '0;
      tx_d  = tx_byte;
    end else if (act_q) begin
      if (tick) begin
        div_d = '0;
        if (!sck) begin
          sck_d = 1'b1;                        // rising: sample
          rx_d  = {rx_byte[6:0], miso};
        end else begin
          sck_d = 1'b0;                        // falling: shift out
          if (bit_q == 3'd7) begin
            act_d  = 1'b0;
            done_d = 1'b1;
          end else begin
            bit_d = bit_q + 3'd1;
            tx_d  = {tx_q[6:0], 1'b0};
          end
        end
      end else begin
        div_d = div_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      sck       <= 1'b0;
      div_q     <= '0;
      bit_q     <= '0;
      tx_q      <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else begin
      act_q     <= act_d;
      sck       <= sck_d;
      div_q     <= div_d;
      bit_q     <= bit_d;
      tx_q      <= tx_d;
      rx_byte   <= rx_d;
      byte_done <= done_d;
    end
  end

  assign mosi = tx_q[7];
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [3:0]         cfg_cycle,
  input  logic [CNT_W-1:0]   cfg_count,
  input  logic [FADDR_W-1:0] cfg_addr,
  output logic [BUF_AW-1:0]  buf_idx,
  input  logic [7:0]         buf_rbyte,
  output logic               buf_we,
  output logic               set_done,
  output logic               set_err,
  output logic               busy,
  output logic               cs_n,
  output logic               sh_start,
  output logic [7:0]         sh_tx,
  input  logic               sh_done
);
  seq_state_e st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic launch_d;

  logic op_ok, need_wren, has_addr, rd_dat, wr_dat;
  logic [7:0] opcode;
  logic [IDX_W-1:0] ndata, hdr, last_idx, data_pos;
  logic [PAGE_BITS+1:0] span_end;
  logic crosses;

  // cycle-type decode
  always_comb begin
    op_ok = 1'b1; need_wren = 1'b0; has_addr = 1'b1;
    rd_dat = 1'b0; wr_dat = 1'b0; opcode = OPC_READ; ndata = '0;
    case (cfg_cycle)
      CYC_READ:  begin rd_dat = 1'b1; ndata = {1'b0, cfg_count} + IDX_W'(1); end
      CYC_PROG:  begin opcode = OPC_PROG; need_wren = 1'b1; wr_dat = 1'b1;
                       ndata = {1'b0, cfg_count} + IDX_W'(1); end
      CYC_ER4K:  begin opcode = OPC_ER4K;  need_wren = 1'b1; end
      CYC_ER64K: begin opcode = OPC_ER64K; need_wren = 1'b1; end
      CYC_RDSR:  begin opcode = OPC_RDSR; has_addr = 1'b0; rd_dat = 1'b1;
                       ndata = IDX_W'(1); end
      default:   op_ok = 1'b0;
    endcase
  end

  always_comb begin
    span_end = {2'b00, cfg_addr[PAGE_BITS-1:0]} + (PAGE_BITS+2)'(cfg_count) + (PAGE_BITS+2)'(1);
    crosses  = (rd_dat | wr_dat) & has_addr & (span_end > (PAGE_BITS+2)'(1 << PAGE_BITS));
    hdr      = has_addr ? IDX_W'(4) : IDX_W'(1);
    last_idx = hdr + ndata - IDX_W'(1);
    data_pos = idx_q - hdr;
  end

  assign buf_idx = data_pos[BUF_AW-1:0];
  assign busy    = (st_q != S_IDLE);
  assign cs_n    = !((st_q == S_WREN) || (st_q == S_XFER));

  // byte to shift for the current position of the transaction
  always_comb begin
    if (st_q == S_WREN)                   sh_tx = OPC_WREN;
    else if (idx_q == '0)                 sh_tx = opcode;
    else if (has_addr && idx_q == IDX_W'(1)) sh_tx = cfg_addr[23:16];
    else if (has_addr && idx_q == IDX_W'(2)) sh_tx = cfg_addr[15:8];
    else if (has_addr && idx_q == IDX_W'(3)) sh_tx = cfg_addr[7:0];
    else                                  sh_tx = buf_rbyte;
  end

  always_comb begin
    st_d = st_q; idx_d = idx_q; launch_d = 1'b0;
    set_done = 1'b0; set_err = 1'b0; buf_we = 1'b0;
    case (st_q)
      S_IDLE: if (go) begin
        if (!op_ok || crosses) set_err = 1'b1;
        else begin
          idx_d = '0; launch_d = 1'b1;
          st_d  = need_wren ? S_WREN : S_XFER;
        end
      end
      S_WREN: if (sh_done) st_d = S_GAP;
      S_GAP:  begin st_d = S_XFER; idx_d = '0; launch_d = 1'b1; end
      S_XFER: if (sh_done) begin
        if (rd_dat && idx_q >= hdr) buf_we = 1'b1;
        if (idx_q == last_idx) st_d = S_FIN;
        else begin idx_d = idx_q + IDX_W'(1); launch_d = 1'b1; end
      end
      S_FIN:  begin set_done = 1'b1; st_d = S_IDLE; end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      idx_q    <= '0;
      sh_start <= 1'b0;
    end else begin
      st_q     <= st_d;
      idx_q    <= idx_d;
      sh_start <= launch_d;
    end
  end
endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top
  import flash_seq_pkg::*;
#(
  parameter int SCK_HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic               fsm_busy, set_done, set_err, go_pulse;
  logic [3:0]         cfg_cycle;
  logic [CNT_W-1:0]   cfg_count;
  logic [FADDR_W-1:0] cfg_addr;
  logic [BUF_AW-1:0]  buf_idx;
  logic [7:0]         buf_rbyte, sh_rx, sh_tx;
  logic               buf_we, flag_done, flag_err;
  logic               sh_start, sh_done, cs_n_int;

  flash_seq_regs u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .bus_wr(reg_wr), .bus_addr(reg_addr), .bus_wdata(reg_wdata), .bus_rdata(reg_rdata),
    .fsm_busy(fsm_busy), .set_done(set_done), .set_err(set_err), .go_pulse(go_pulse),
    .cfg_cycle(cfg_cycle), .cfg_count(cfg_count), .cfg_addr(cfg_addr),
    .buf_idx(buf_idx), .buf_rbyte(buf_rbyte), .buf_we(buf_we), .buf_wbyte(sh_rx),
    .flag_done(flag_done), .flag_err(flag_err)
  );

  flash_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_int_n), .go(go_pulse),
    .cfg_cycle(cfg_cycle), .cfg_count(cfg_count), .cfg_addr(cfg_addr),
    .buf_idx(buf_idx), .buf_rbyte(buf_rbyte), .buf_we(buf_we),
    .set_done(set_done), .set_err(set_err), .busy(fsm_busy), .cs_n(cs_n_int),
    .sh_start(sh_start), .sh_tx(sh_tx), .sh_done(sh_done)
  );

  flash_seq_shifter #(.HALF_DIV(SCK_HALF_DIV)) u_shift (
    .clk(clk), .rst_n(rst_int_n), .start(sh_start), .tx_byte(sh_tx),
    .byte_done(sh_done), .rx_byte(sh_rx),
    .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso)
  );

  assign spi_cs_n = cs_n_int;
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic       cs_n,
  input logic       busy,
  input logic       done_flag,
  input logic       err_flag,
  input logic [3:0] cfg_cycle
);
  // R10: serial clock idles low while the flash is deselected
  p_sck_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R2: completion is flagged only after chip select has been released
  p_done_after_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(cs_n));

  // R7: a rejected request never touches chip select
  p_err_without_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> (cs_n && $past(cs_n)));

  // R9: configuration written during a running cycle is dropped
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg_cycle));
endmodule

bind flash_seq_top flash_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n),
  .busy(fsm_busy), .done_flag(flag_done), .err_flag(flag_err), .cfg_cycle(cfg_cycle)
);

// File: tb/flash_seq_top_tb_top.sv
module flash_seq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  bit mon_on = 1'b0;

  always #5 clk = ~clk;

  flash_seq_top #(.SCK_HALF_DIV(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // ---------------- behavioural serial flash ----------------
  bit [7:0] mem [int];
  bit       wel = 1'b0;
  bit       txn_open = 1'b0;
  localparam logic [7:0] STATUS_VAL = 8'h5C;
  int  bitc, bytec, rises, f_addr;
  logic [7:0] f_op, shin, outb;
  logic [7:0] wq[$];
  int op_q[$], adr_q[$], rise_q[$];

  function automatic logic [7:0] rdmem(int a);
    return mem.exists(a) ? mem[a] : 8'hFF;
  endfunction

  always @(negedge spi_cs_n) begin
    txn_open = 1'b1; bitc = 0; bytec = 0; rises = 0; f_addr = 0; f_op = 8'h00;
    wq.delete();
  end

  always @(posedge spi_sck) if (txn_open && !spi_cs_n) begin
    shin = {shin[6:0], spi_mosi};
    bitc++; rises++;
    if (bitc == 8) begin
      if (bytec == 0) begin f_op = shin; if (shin == 8'h06) wel = 1'b1; end
      else if (bytec <= 3) f_addr = (f_addr << 8) | int'(shin);
      else if (f_op == 8'h02) wq.push_back(shin);
      bitc = 0; bytec++;
    end
  end

  always @(negedge spi_sck) if (txn_open && !spi_cs_n) begin
    if ((f_op == 8'h03 && bytec >= 4) || (f_op == 8'h05 && bytec >= 1)) begin
      if (bitc == 0) outb = (f_op == 8'h05) ? STATUS_VAL : rdmem(f_addr + bytec - 4);
      spi_miso = outb[7];
      outb = {outb[6:0], 1'b0};
    end
  end

  always @(posedge spi_cs_n) if (txn_open) begin
    txn_open = 1'b0;
    op_q.push_back(int'(f_op)); adr_q.push_back(f_addr); rise_q.push_back(rises);
    if (wel) begin
      if (f_op == 8'h02) foreach (wq[i]) mem[f_addr + i] = wq[i];
      if (f_op == 8'h20) for (int a = 0; a < 4096; a++) mem.delete((f_addr & ~32'hFFF) + a);
      if (f_op == 8'hD8) for (int a = 0; a < 65536; a++) mem.delete((f_addr & ~32'hFFFF) + a);
    end
    if (f_op == 8'h02 || f_op == 8'h20 || f_op == 8'hD8) wel = 1'b0;
  end

  // ---------------- per-clock mode-0 idle check (R10) ----------------
  always @(negedge clk) if (mon_on) begin
    vectors++;
    if (spi_cs_n === 1'b1 && spi_sck !== 1'b0) begin
      miscompares++;
      $display("FAIL R10: sck actual %b expected 0 while deselected", spi_sck);
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] ctl_word(logic [3:0] cyc, logic [5:0] cnt);
    return {2'b00, cnt, 3'b000, cyc, 1'b1, 16'h00FF};
  endfunction

  task automatic start(input logic [3:0] cyc, input logic [5:0] cnt, input int a);
    op_q.delete(); adr_q.delete(); rise_q.delete();
    wr(8'h08, 32'(a));
    wr(8'h04, ctl_word(cyc, cnt));
  endtask

  task automatic wait_end(output logic [31:0] v);
    for (int i = 0; i < 40000; i++) begin
      rd(8'h04, v);
      if (v[1:0] != 2'b00) break;
    end
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(int i, int s);
    return 8'((i * s + 3) & 8'hFF);
  endfunction

  task automatic fill_buf(input int s);
    for (int k = 0; k < 16; k++)
      wr(8'h10 + 8'(4 * k), {pat(4*k+3, s), pat(4*k+2, s), pat(4*k+1, s), pat(4*k, s)});
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // R1 reset state
    rd(8'h04, v); chk("R1 ctl", v, 32'h0);
    rd(8'h08, v); chk("R1 addr", v, 32'h0);
    chk("R1 cs_n", 32'(spi_cs_n), 32'h1);
    chk("R1 sck", 32'(spi_sck), 32'h0);

    // R2 read 5 bytes
    for (int i = 0; i < 5; i++) mem[32'h123 + i] = 8'h40 + 8'(i);
    start(4'd0, 6'd4, 32'h123);
    wait_end(v);
    chk("R2 done", 32'(v[1:0]), 32'h1);
    chk("R2 txn count", op_q.size(), 1);
    chk("R2 opcode", op_q[0], 32'h03);
    chk("R2 address", adr_q[0], 32'h123);
    chk("R2 clocks", rise_q[0], 72);
    rd(8'h10, v); chk("R2 buf dw0", v, 32'h43424140);
    rd(8'h14, v); chk("R2 buf byte4", 32'(v[7:0]), 32'h44);

    // R8 write-one-to-clear
    wr(8'h04, 32'h2); rd(8'h04, v); chk("R8 done kept", 32'(v[0]), 32'h1);
    wr(8'h04, 32'h1); rd(8'h04, v); chk("R8 done cleared", 32'(v[0]), 32'h0);

    // R3 program 8 bytes, with R9 busy and ignored go
    fill_buf(7);
    start(4'd2, 6'd7, 32'h200);
    rd(8'h04, v); chk("R9 busy bit", 32'(v[5]), 32'h1);
    wr(8'h04, {2'b00, 6'd0, 3'b000, 4'd0, 1'b1, 16'h0000});
    wait_end(v);
    chk("R9 cycle field kept", 32'(v[20:17]), 32'd2);
    chk("R9 no extra txn", op_q.size(), 2);
    chk("R3 wren", op_q[0], 32'h06);
    chk("R3 wren clocks", rise_q[0], 8);
    chk("R3 opcode", op_q[1], 32'h02);
    chk("R3 address", adr_q[1], 32'h200);
    chk("R3 clocks", rise_q[1], 96);
    for (int i = 0; i < 8; i++) chk("R3 flash byte", 32'(rdmem(32'h200 + i)), 32'(pat(i, 7)));
    chk("R3 beyond count", 32'(rdmem(32'h208)), 32'hFF);
    rd(8'h04, v); chk("R9 busy clear", 32'(v[5]), 32'h0);

    // R11 full 64-byte program and read back
    fill_buf(13);
    start(4'd2, 6'd63, 32'h300);
    wait_end(v);
    chk("R11 prog done", 32'(v[1:0]), 32'h1);
    for (int k = 0; k < 16; k++) wr(8'h10 + 8'(4 * k), 32'h0);
    start(4'd0, 6'd63, 32'h300);
    wait_end(v);
    chk("R11 read clocks", rise_q[0], 8 * 68);
    for (int k = 0; k < 16; k++) begin
      rd(8'h10 + 8'(4 * k), v);
      chk("R11 dword", v, {pat(4*k+3, 13), pat(4*k+2, 13), pat(4*k+1, 13), pat(4*k, 13)});
    end

    // R6 page boundary
    start(4'd0, 6'd16, 32'h1F0);
    wait_end(v);
    chk("R6 crossing err", 32'(v[1:0]), 32'h2);
    chk("R6 crossing no txn", op_q.size(), 0);
    start(4'd0, 6'd15, 32'h1F0);
    wait_end(v);
    chk("R6 exact end done", 32'(v[1:0]), 32'h1);
    chk("R6 exact end txn", op_q.size(), 1);

    // R7 unsupported cycle types
    start(4'd1, 6'd0, 32'h0);
    wait_end(v);
    chk("R7 type1 err", 32'(v[1:0]), 32'h2);
    chk("R7 type1 no txn", op_q.size(), 0);
    start(4'hF, 6'd3, 32'h0);
    wait_end(v);
    chk("R7 type15 err", 32'(v[1:0]), 32'h2);
    chk("R7 type15 no txn", op_q.size(), 0);

    // R4 4 KiB erase, count field ignored
    mem[32'h1000] = 8'h77;
    start(4'd3, 6'd5, 32'h100);
    wait_end(v);
    chk("R4 er4k done", 32'(v[1:0]), 32'h1);
    chk("R4 er4k txns", op_q.size(), 2);
    chk("R4 er4k wren", op_q[0], 32'h06);
    chk("R4 er4k opcode", op_q[1], 32'h20);
    chk("R4 er4k clocks", rise_q[1], 32);
    start(4'd0, 6'd3, 32'h300);
    wait_end(v);
    rd(8'h10, v); chk("R4 erased data", v, 32'hFFFFFFFF);
    start(4'd0, 6'd0, 32'h1000);
    wait_end(v);
    rd(8'h10, v); chk("R4 next sector kept", 32'(v[7:0]), 32'h77);

    // R4 64 KiB erase
    mem[32'h10005] = 8'h11;
    start(4'd4, 6'd63, 32'h10000);
    wait_end(v);
    chk("R4 er64k opcode", op_q.size() == 2 ? op_q[1] : -1, 32'hD8);
    chk("R4 er64k clocks", rise_q.size() == 2 ? rise_q[1] : -1, 32);
    chk("R4 er64k erased", 32'(rdmem(32'h10005)), 32'hFF);

    // R5 status read
    start(4'd8, 6'd9, 32'h0);
    wait_end(v);
    chk("R5 done", 32'(v[1:0]), 32'h1);
    chk("R5 opcode", op_q.size() == 1 ? op_q[0] : -1, 32'h05);
    chk("R5 clocks", rise_q.size() == 1 ? rise_q[0] : -1, 16);
    rd(8'h10, v); chk("R5 status byte", 32'(v[7:0]), 32'(STATUS_VAL));

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule